// File: doc/BRIEF.md
# Command-Word SPI Master

This block is a register-programmed SPI master. Software writes the outgoing bits into a transmit register, sets a clock divider, and then writes one command word. That word starts the shift, picks which of three active-low chip selects to assert, says whether to release the chip select at the end, and gives the number of bits to move, up to 32. The engine runs SPI mode 0 on SCK and MOSI, and it samples MISO into a receive register. When the last bit has gone out, it clears the start bit of the command register. Software polls that bit to learn that the transfer is complete.

A transaction longer than 32 bits is built from several commands. Every command except the last leaves the terminate flag clear. The chip select then stays asserted between commands and SCK rests low. When no chip select is held, the SCK, MOSI and chip-select pins take idle levels from a pin-control register.

Top module: `spi_shift_ctrl`

## Requirements
- R1: After reset, every register reads zero except the pin-control register (offset 0x08), which reads 0x0007_0000. The pins then show spi_cs_n = 3'b111, spi_sck = 0 and spi_mosi = 0.
- R2: A write to offset 0x14 with bit 31 set starts a command. Bits 30:28 form the chip-select mask (bit 28+n selects spi_cs_n[n]), bit 26 is the terminate flag, and bits 5:0 give the bit count; a count above 32 is treated as 32. Bit 31 of a read at 0x14 is 1 while the command runs and 0 once it is done.
- R3: For a count of N, the N low bits of the transmit register (offset 0x10) are sent most significant bit first, starting with bit N-1. Bits above N-1 are never sent.
- R4: The clock-control register (offset 0x04, bits 5:0 = div) sets each SCK half period to div+1 clock cycles. A command of N bits keeps the busy bit set for exactly 2·N·(div+1) cycles and produces exactly N rising SCK edges. MOSI changes only at the start of the command or on a falling SCK edge, and MISO is sampled on the rising edge.
- R5: The receive register (offset 0x18) holds the N received bits right-aligned, with the last received bit in bit 0 and zeros above. It changes only when a command completes.
- R6: The selected chip selects go low when the command starts. If terminate is set, they return high when the last bit is done. If terminate is clear, they stay low after completion with SCK held low.
- R7: Bit 0 of offset 0x00 enables the controller. While it is 0, a command write starts nothing and moves no pin.
- R8: A command written while one is still running is ignored. It does not change the running count, the chip selects or the register contents.
- R9: A bit count of 0 completes at once. It produces no SCK edge and loads the receive register with zero.
- R10: While no chip select is held, the pin-control register sets the idle pins: bits 18:16 give the spi_cs_n levels, bit 8 gives the SCK level and bit 0 gives the MOSI level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wdata | input | WORD_W (32) | Write data |
| bus_rdata | output | WORD_W (32) | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS (3) | Active-low chip selects |

## Verification
The bench builds the block with its default parameters: a 32-bit word, three chip selects and a 6-bit divider. With these values the full-word shift, the count clamp above 32 and the split of a 48-bit transaction into a held command and a terminating one are all reachable. Divider values 0, 2 and 3 exercise both the fastest SCK and slower ones. The cycle count of each command is checked against 2·N·(div+1). A loopback slave model in the bench checks the bit order in both directions.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
    // register offsets; software depends on these
    localparam logic [4:0] OFS_ENABLE = 5'h00;
    localparam logic [4:0] OFS_CLKDIV = 5'h04;
    localparam logic [4:0] OFS_PINCTL = 5'h08;
    localparam logic [4:0] OFS_TXDATA = 5'h10;
    localparam logic [4:0] OFS_SHIFT  = 5'h14;
    localparam logic [4:0] OFS_RXDATA = 5'h18;

    // command word field positions
    localparam int CMD_GO     = 31;
    localparam int CMD_SEL_LO = 28;
    localparam int CMD_TERM   = 26;

    // pin-control field positions
    localparam int PIN_CS_LO = 16;
    localparam int PIN_SCK   = 8;
    localparam int PIN_MOSI  = 0;

    localparam logic [31:0] PINCTL_RESET = 32'h0007_0000;
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 6,
    parameter int CNT_W  = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  bits_i,
    input  logic [WORD_W-1:0] tx_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sck_o,
    output logic              mosi_o,
    output logic [WORD_W-1:0] rx_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [DIV_W-1:0]  div;
        logic [DIV_W-1:0]  half;
        logic [CNT_W-1:0]  left;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] rx_hold;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                if (bits_i == '0) begin
                    d.rx_hold = '0;
                    done_o    = 1'b1;
                end else begin
                    d.busy = 1'b1;
                    d.sck  = 1'b0;
                    d.div  = div_i;
                    d.half = div_i;
                    d.left = bits_i;
                    // left-justify so the first bit sits in the top position
                    d.tx   = tx_i << (FULL - bits_i);
                    d.rx   = '0;
                end
            end
        end else if (q.half != '0) begin
            d.half = q.half - 1'b1;
        end else begin
            d.half = q.div;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[WORD_W-2:0], miso_i};
            end else begin
                d.sck = 1'b0;
                if (q.left == CNT_W'(1)) begin
                    d.busy    = 1'b0;
                    d.rx_hold = q.rx;
                    done_o    = 1'b1;
                end else begin
                    d.left = q.left - 1'b1;
                    d.tx   = q.tx << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign sck_o  = q.sck;
    assign mosi_o = q.tx[WORD_W-1];
    assign rx_o   = q.rx_hold;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_shift_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 6,
    parameter int NUM_CS = 3,
    parameter int CNT_W  = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [WORD_W-1:0] rx_i,
    output logic              start_o,
    output logic [CNT_W-1:0]  bits_o,
    output logic [WORD_W-1:0] tx_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [NUM_CS-1:0] held_o,
    output logic [WORD_W-1:0] pin_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic              en;
        logic [DIV_W-1:0]  div;
        logic [WORD_W-1:0] pin;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] cmd;
        logic [NUM_CS-1:0] held;
    } regs_t;

    regs_t q, d;
    logic  hit_shift;
    logic  term;

    always_comb begin
        d         = q;
        hit_shift = wr_i && (addr_i == ADDR_W'(OFS_SHIFT));
        start_o   = hit_shift && wdata_i[CMD_GO] && q.en && !busy_i;
        bits_o    = (wdata_i[CNT_W-1:0] > FULL) ? FULL : wdata_i[CNT_W-1:0];
        term      = start_o ? wdata_i[CMD_TERM] : q.cmd[CMD_TERM];

        if (wr_i) begin
            case (addr_i)
                ADDR_W'(OFS_ENABLE): d.en  = wdata_i[0];
                ADDR_W'(OFS_CLKDIV): d.div = wdata_i[DIV_W-1:0];
                ADDR_W'(OFS_PINCTL): d.pin = wdata_i;
                ADDR_W'(OFS_TXDATA): d.tx  = wdata_i;
                default: ;
            endcase
        end
        if (start_o) begin
            d.cmd         = wdata_i;
            d.cmd[CMD_GO] = 1'b0;
            d.held        = wdata_i[CMD_SEL_LO +: NUM_CS];
        end
        if (done_i && term) begin
            d.held = '0;
        end

        case (addr_i)
            ADDR_W'(OFS_ENABLE): rdata_o = {{(WORD_W-1){1'b0}}, q.en};
            ADDR_W'(OFS_CLKDIV): rdata_o = {{(WORD_W-DIV_W){1'b0}}, q.div};
            ADDR_W'(OFS_PINCTL): rdata_o = q.pin;
            ADDR_W'(OFS_TXDATA): rdata_o = q.tx;
            ADDR_W'(OFS_SHIFT):  rdata_o = {busy_i, q.cmd[WORD_W-2:0]};
            ADDR_W'(OFS_RXDATA): rdata_o = rx_i;
            default:             rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.pin <= WORD_W'(PINCTL_RESET);
        end else begin
            q <= d;
        end
    end

    assign tx_o   = q.tx;
    assign div_o  = q.div;
    assign held_o = q.held;
    assign pin_o  = q.pin;
endmodule

// File: rtl/spi_pin_drive.sv
module spi_pin_drive
    import spi_shift_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NUM_CS = 3
) (
    input  logic              busy_i,
    input  logic              eng_sck_i,
    input  logic              eng_mosi_i,
    input  logic [NUM_CS-1:0] held_i,
    input  logic [WORD_W-1:0] pin_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic [NUM_CS-1:0] cs_n_o
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n_o[g] = held_i[g] ? 1'b0 : pin_i[PIN_CS_LO + g];
    end

    always_comb begin
        if (busy_i) begin
            sck_o  = eng_sck_i;
            mosi_o = eng_mosi_i;
        end else begin
            sck_o  = (|held_i) ? 1'b0 : pin_i[PIN_SCK];
            mosi_o = pin_i[PIN_MOSI];
        end
    end
endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 6,
    parameter int NUM_CS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam int CNT_W = $clog2(WORD_W) + 1;

    logic              eng_start;
    logic [CNT_W-1:0]  eng_bits;
    logic [WORD_W-1:0] eng_tx;
    logic [DIV_W-1:0]  eng_div;
    logic              eng_busy;
    logic              eng_done;
    logic              eng_sck;
    logic              eng_mosi;
    logic [WORD_W-1:0] eng_rx;
    logic [NUM_CS-1:0] cs_held;
    logic [WORD_W-1:0] pin_ctl;

    spi_reg_bank #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
        .NUM_CS(NUM_CS), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .busy_i(eng_busy), .done_i(eng_done), .rx_i(eng_rx),
        .start_o(eng_start), .bits_o(eng_bits), .tx_o(eng_tx), .div_o(eng_div),
        .held_o(cs_held), .pin_o(pin_ctl)
    );

    spi_bit_engine #(
        .WORD_W(WORD_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_i(eng_start), .bits_i(eng_bits), .tx_i(eng_tx), .div_i(eng_div),
        .miso_i(spi_miso),
        .busy_o(eng_busy), .done_o(eng_done), .sck_o(eng_sck), .mosi_o(eng_mosi),
        .rx_o(eng_rx)
    );

    spi_pin_drive #(
        .WORD_W(WORD_W), .NUM_CS(NUM_CS)
    ) u_pins (
        .busy_i(eng_busy), .eng_sck_i(eng_sck), .eng_mosi_i(eng_mosi),
        .held_i(cs_held), .pin_i(pin_ctl),
        .sck_o(spi_sck), .mosi_o(spi_mosi), .cs_n_o(spi_cs_n)
    );
endmodule

// File: rtl/spi_shift_ctrl_checker.sv
module spi_shift_ctrl_checker #(
    parameter int NUM_CS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [NUM_CS-1:0] held,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n
);
    // R4: data line moves only on a falling clock edge while a command runs
    a_r4_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$fell(sck) |-> $stable(mosi));

    // R6: chip selects stay fixed for the whole command
    a_r6_cs_fixed_in_command: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cs_n));

    // R6: between held commands the clock rests low
    a_r6_sck_low_between: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && (|held) |-> !sck);

    // R8: a second command cannot change the held mask mid-transfer
    a_r8_held_steady: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(held));

    // R4: every command begins with the clock low
    a_r4_start_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !sck);
endmodule

bind spi_shift_ctrl spi_shift_ctrl_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .held(cs_held),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n)
);

// File: tb/spi_shift_ctrl_test.sv
module spi_shift_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [2:0]  spi_cs_n;

    always #2 clk = ~clk;

    spi_shift_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] last_rx = '0;

    // loopback slave, mode 0
    logic [31:0] slv_sr = '0, mosi_log = '0, load_val = '0;
    int          rises = 0;
    logic        load_pulse = 1'b0;
    assign spi_miso = slv_sr[31];
    always @(posedge spi_sck or posedge load_pulse) begin
        if (load_pulse) begin
            slv_sr   <= load_val;
            mosi_log <= '0;
            rises    <= 0;
        end else begin
            mosi_log <= {mosi_log[30:0], spi_mosi};
            slv_sr   <= slv_sr << 1;
            rises    <= rises + 1;
        end
    end

    typedef struct {
        logic [31:0] rx;
        logic [31:0] sent;
        int          cycles;
        int          edges;
        string       tag;
    } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic slave_load(input logic [31:0] v);
        load_val = v;
        load_pulse = 1'b1;
        #1 load_pulse = 1'b0;
    endtask

    task automatic poll(output int k);
        logic [31:0] v;
        k = 0;
        forever begin
            bus_read(5'h14, v);
            if (!v[31] || k > 5000) break;
            @(posedge clk);
            k++;
        end
    endtask

    function automatic logic [31:0] low_mask(input int n);
        logic [63:0] m = (64'd1 << n) - 64'd1;
        return m[31:0];
    endfunction

    // driver: pushes the expected result, runs the command, hands over the actual one
    task automatic xfer(input logic [2:0] sel, input bit term, input int field, input int n,
                        input logic [31:0] tx, input logic [31:0] stx, input int dv, input string tag);
        item_t e, a;
        int k;
        logic [31:0] v;
        e.rx = stx & low_mask(n);
        e.sent = tx & low_mask(n);
        e.cycles = 2 * n * (dv + 1);
        e.edges = n;
        e.tag = tag;
        exp_q.push_back(e);
        bus_write(5'h04, 32'(dv));
        bus_write(5'h10, tx);
        slave_load(n == 0 ? 32'h0 : (stx << (32 - n)));
        bus_write(5'h14, 32'h8000_0000 | (32'(sel) << 28) | (32'(term) << 26) | 32'(field));
        poll(k);
        bus_read(5'h18, v);
        a.rx = v; a.sent = mosi_log & low_mask(n); a.cycles = k; a.edges = rises; a.tag = tag;
        act_q.push_back(a);
        last_rx = v;
        wait (act_q.size() == 0);
        #1;
        // R6: chip-select level after completion
        check(spi_cs_n == (term ? 3'b111 : ~sel), {"R6 cs after ", tag}, 32'(spi_cs_n), 32'(term ? 3'b111 : ~sel));
    endtask

    // monitor: compares design results against the scoreboard
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                item_t e, a;
                e = exp_q.pop_front();
                a = act_q[0];
                check(a.rx == e.rx, {"R5 data-in ", e.tag}, a.rx, e.rx);
                check(a.sent == e.sent, {"R3 mosi bits ", e.tag}, a.sent, e.sent);
                check(a.cycles == e.cycles, {"R4 busy cycles ", e.tag}, 32'(a.cycles), 32'(e.cycles));
                check(a.edges == e.edges, {"R4 sck rises ", e.tag}, 32'(a.edges), 32'(e.edges));
                void'(act_q.pop_front());
            end
        end
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(5'h00, v); check(v == 0, "R1 enable reset", v, 0);
        bus_read(5'h04, v); check(v == 0, "R1 clkdiv reset", v, 0);
        bus_read(5'h08, v); check(v == 32'h0007_0000, "R1 pinctl reset", v, 32'h0007_0000);
        bus_read(5'h14, v); check(v == 0, "R1 shift reset", v, 0);
        bus_read(5'h18, v); check(v == 0, "R1 data-in reset", v, 0);
        check({spi_cs_n, spi_sck, spi_mosi} == 5'b11100, "R1 idle pins",
              32'({spi_cs_n, spi_sck, spi_mosi}), 32'h1c);

        // R7 disabled controller ignores commands
        slave_load(32'h0);
        bus_write(5'h14, 32'h9400_0008);
        repeat (20) @(posedge clk);
        bus_read(5'h14, v); check(v[31] == 1'b0, "R7 no busy while disabled", v, 0);
        check(spi_cs_n == 3'b111 && rises == 0, "R7 pins quiet while disabled",
              32'({spi_cs_n, 8'(rises)}), 32'h700);

        bus_write(5'h00, 32'h1);
        // R2 R3 R4 R5 R6 single byte, fastest clock
        xfer(3'b001, 1'b1, 8, 8, 32'h0000_00A5, 32'h0000_003C, 0, "byte cs0 div0");
        // R6 held 32-bit command followed by a terminating 16-bit one
        xfer(3'b010, 1'b0, 32, 32, 32'hDEAD_BEEF, 32'h1234_5678, 2, "word cs1 hold");
        repeat (5) @(negedge clk);
        check(spi_sck == 1'b0 && spi_cs_n == 3'b101, "R6 sck low while held",
              32'({spi_cs_n, spi_sck}), 32'hA);
        xfer(3'b010, 1'b1, 16, 16, 32'hFFFF_1234, 32'h0000_BEEF, 2, "half cs1 term");
        // R9 zero count
        xfer(3'b001, 1'b1, 0, 0, 32'h0000_00FF, 32'h0, 1, "R9 zero count");
        // R2 count above 32 clamps to 32
        xfer(3'b100, 1'b1, 40, 32, 32'h0F0F_0F0F, 32'hCAFE_F00D, 0, "R2 clamp 40");

        // R8 command during busy is ignored; R5 data-in steady meanwhile
        bus_write(5'h04, 32'd3);
        bus_write(5'h10, 32'h0000_0081);
        slave_load(32'hC300_0000);
        bus_write(5'h14, 32'hC400_0008);
        repeat (10) @(posedge clk);
        bus_write(5'h14, 32'h9000_0004);
        bus_read(5'h14, v);
        check(v[31] == 1'b1 && v[5:0] == 6'd8, "R8 running count kept", v, 32'hC400_0008);
        check(spi_cs_n == 3'b011, "R8 cs unchanged", 32'(spi_cs_n), 32'h3);
        bus_read(5'h18, v); check(v == last_rx, "R5 data-in steady while busy", v, last_rx);
        begin
            int k;
            poll(k);
        end
        bus_read(5'h18, v); check(v == 32'h0000_00C3, "R8 first command result", v, 32'hC3);
        check(rises == 8 && spi_cs_n == 3'b111, "R8 eight edges then release",
              32'({spi_cs_n, 8'(rises)}), 32'h708);
        bus_read(5'h10, v); check(v == 32'h81, "R8 data-out untouched", v, 32'h81);

        // R10 idle levels from pin control
        bus_write(5'h08, 32'h0005_0101);
        #1 check({spi_cs_n, spi_sck, spi_mosi} == 5'b10111, "R10 idle pins follow pinctl",
                 32'({spi_cs_n, spi_sck, spi_mosi}), 32'h17);
        bus_write(5'h08, 32'h0007_0000);
        #1 check({spi_cs_n, spi_sck, spi_mosi} == 5'b11100, "R10 idle pins restored",
                 32'({spi_cs_n, spi_sck, spi_mosi}), 32'h1c);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule